// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block takes one asynchronous trigger pin from outside the chip and turns it into a clean signal in the timer clock domain. The pin first passes through a synchroniser. An optional inversion makes either level or either edge the active one. An optional prescaler then divides the rate of active edges by 2, 4 or 8. Last comes a digital glitch filter that moves its output only after a run of agreeing samples.

A downstream counter or slave-mode controller uses two outputs: the filtered level, and a one-cycle pulse on each rising transition of that level. All settings are static configuration inputs that reset to zero, which means no inversion, no prescaling and no filtering.

The filter setting picks both how often the filter samples and how many samples in a row must agree. Sampling runs either at the internal clock or at a slower dead-time rate divided down further. The dead-time rate is a clock enable taken from the internal clock by a ratio of 1, 2 or 4. After prescaling, the conditioned trigger is expected to toggle at no more than a quarter of the internal clock rate; the prescaler exists to bring fast external clocks under that limit.

Top module: `ext_trig_conditioner`

## Requirements
- R1: While `rst_n` is low, `trig_level` and `trig_rise` are 0, and every internal count and level returns to its start value.
- R2: The pin passes through two synchroniser flops. With `cfg_invert` = 0 the pin is used as it is (high level and rising edge are active). With `cfg_invert` = 1 it is inverted (low level and falling edge are active).
- R3: `cfg_presc` code 0 bypasses the prescaler. Codes 1, 2 and 3 toggle the prescaler output once every 1, 2 or 4 rising edges of the polarity-corrected signal, so the edge rate is divided by 2, 4 or 8. Between edges, the prescaler output holds.
- R4: The filter output changes only when N samples in a row differ from the current output. Any sample equal to the current output restarts the run.
- R5: `cfg_filt` selects the sampling rate and N as follows. 1, 2, 3: every internal clock cycle, N = 2, 4, 8. 4, 5: dead-time rate / 2, N = 6, 8. 6, 7: / 4, N = 6, 8. 8, 9: / 8, N = 6, 8. 10, 11, 12: / 16, N = 5, 6, 8. 13, 14, 15: / 32, N = 5, 6, 8.
- R6: With `cfg_filt` = 0 the filter takes every sample at the dead-time rate (N = 1). With ratio 1 and no prescaling, `trig_level` follows a pin change at the third rising clock edge after the change.
- R7: `cfg_dt_sel` encodes the dead-time ratio: 0 gives 1, 1 gives 2, and 2 or 3 give 4 internal clock cycles per dead-time tick.
- R8: In a cycle where `cfg_filt` differs from the value seen in the previous cycle, the sample divider and the run count are cleared, no sample is taken, and `trig_level` does not change.
- R9: `trig_rise` is high for exactly one clock cycle, the first cycle in which `trig_level` is 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pin | input | 1 | Raw asynchronous trigger pin |
| cfg_invert | input | 1 | 1 inverts the pin (low / falling edge active) |
| cfg_presc | input | 2 | Edge prescaler code: 0 off, 1 /2, 2 /4, 3 /8 |
| cfg_filt | input | 4 | Filter code: sampling rate and required run length |
| cfg_dt_sel | input | 2 | Dead-time ratio: 0 = 1, 1 = 2, 2 or 3 = 4 |
| trig_level | output | 1 | Filtered, conditioned trigger level |
| trig_rise | output | 1 | One-cycle pulse on each rising transition of trig_level |

## Verification
A change of the filter code can land in the same cycle as the sample that would finish a run and flip the filtered level. In that case the code change wins: the run is discarded and the level holds. The bench provokes this directly by switching the code every cycle while the pin sits against the current level, and again at random inside long random segments where code changes hit arbitrary points of a run. Each cycle is judged against a cycle model in the bench, written from the requirements, which applies the same precedence.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

  localparam int RUN_W = 4;   // holds N up to 8
  localparam int DIV_W = 6;   // holds sampling divisors up to 32
  localparam int DT_W  = 2;   // dead-time counter, ratio up to 4
  localparam int PSC_W = 2;   // prescaler edge counter, up to 4 edges

  // True when the filter samples at the internal clock rate
  function automatic logic filt_fast(input logic [3:0] code);
    return (code == 4'd1) || (code == 4'd2) || (code == 4'd3);
  endfunction

  // Consecutive agreeing samples needed before the output moves
  function automatic logic [RUN_W-1:0] filt_need(input logic [3:0] code);
    case (code)
      4'd0:                      return RUN_W'(1);
      4'd1:                      return RUN_W'(2);
      4'd2:                      return RUN_W'(4);
      4'd10, 4'd13:              return RUN_W'(5);
      4'd4, 4'd6, 4'd8,
      4'd11, 4'd14:              return RUN_W'(6);
      default:                   return RUN_W'(8);
    endcase
  endfunction

  // Divisor applied on top of the dead-time enable
  function automatic logic [DIV_W-1:0] filt_div(input logic [3:0] code);
    case (code)
      4'd4, 4'd5:                return DIV_W'(2);
      4'd6, 4'd7:                return DIV_W'(4);
      4'd8, 4'd9:                return DIV_W'(8);
      4'd10, 4'd11, 4'd12:       return DIV_W'(16);
      4'd13, 4'd14, 4'd15:       return DIV_W'(32);
      default:                   return DIV_W'(1);
    endcase
  endfunction

  // Rising edges between prescaler output toggles (code 0 unused)
  function automatic logic [PSC_W:0] presc_half(input logic [1:0] code);
    case (code)
      2'd2:    return (PSC_W+1)'(2);
      2'd3:    return (PSC_W+1)'(4);
      default: return (PSC_W+1)'(1);
    endcase
  endfunction

  // Internal clock cycles per dead-time tick
  function automatic logic [DT_W:0] dt_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    return (DT_W+1)'(1);
      2'd1:    return (DT_W+1)'(2);
      default: return (DT_W+1)'(4);
    endcase
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  output logic pol_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign pol_out = chain[STAGES-1] ^ invert;
endmodule

// File: rtl/trig_presc.sv
module trig_presc
  import trig_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] code,
  output logic       dout
);
  logic             prev_q;
  logic [PSC_W-1:0] cnt_q;
  logic             tog_q;
  logic             in_edge;
  logic             last_edge;

  assign in_edge   = din & ~prev_q;
  assign last_edge = ({1'b0, cnt_q} + (PSC_W+1)'(1)) >= presc_half(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
    end else begin
      prev_q <= din;
      if (code == 2'd0) begin
        cnt_q <= '0;
      end else if (in_edge) begin
        if (last_edge) begin
          cnt_q <= '0;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + PSC_W'(1);
        end
      end
    end
  end

  assign dout = (code == 2'd0) ? din : tog_q;

  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_edge && code != 2'd0) |=> $stable(tog_q)) else $error("prescaler moved without edge"); // R3
endmodule

// File: rtl/trig_dtgen.sv
module trig_dtgen
  import trig_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       dt_en
);
  logic [DT_W-1:0] cnt_q;

  assign dt_en = ({1'b0, cnt_q} + (DT_W+1)'(1)) >= dt_ratio(sel);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt_q <= '0;
    else if (dt_en) cnt_q <= '0;
    else            cnt_q <= cnt_q + DT_W'(1);

  AST_DT_RATIO1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |-> dt_en) else $error("ratio 1 must tick each cycle"); // R7
endmodule

// File: rtl/trig_filter.sv
module trig_filter
  import trig_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [3:0] code,
  input  logic       dt_en,
  output logic       dout
);
  logic [3:0]       last_code_q;
  logic [DIV_W-1:0] div_q;
  logic [RUN_W-1:0] run_q;
  logic             out_q;
  logic             code_chg;
  logic             div_wrap;
  logic             samp_en;
  logic [RUN_W-1:0] need;

  assign need     = filt_need(code);
  assign code_chg = (code != last_code_q);
  assign div_wrap = (div_q + DIV_W'(1)) >= filt_div(code);
  assign samp_en  = !code_chg && (filt_fast(code) || (dt_en && div_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_code_q <= '0;
      div_q       <= '0;
      run_q       <= '0;
      out_q       <= 1'b0;
    end else if (code_chg) begin
      last_code_q <= code;
      div_q       <= '0;
      run_q       <= '0;
    end else begin
      if (dt_en) div_q <= div_wrap ? '0 : div_q + DIV_W'(1);
      if (samp_en) begin
        if (din == out_q) begin
          run_q <= '0;
        end else if ((run_q + RUN_W'(1)) >= need) begin
          out_q <= din;
          run_q <= '0;
        end else begin
          run_q <= run_q + RUN_W'(1);
        end
      end
    end
  end

  assign dout = out_q;

  AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(samp_en) && (int'($past(run_q)) + 1 == int'($past(need)))))
    else $error("filter moved without full run"); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> $stable(out_q)) else $error("level moved on code change"); // R8
endmodule

// File: rtl/ext_trig_conditioner.sv
module ext_trig_conditioner #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic       cfg_invert,
  input  logic [1:0] cfg_presc,
  input  logic [3:0] cfg_filt,
  input  logic [1:0] cfg_dt_sel,
  output logic       trig_level,
  output logic       trig_rise
);
  logic pol_sig;
  logic psc_sig;
  logic dt_en;
  logic filt_sig;
  logic filt_prev_q;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .invert(cfg_invert), .pol_out(pol_sig)
  );

  trig_presc u_presc (
    .clk(clk), .rst_n(rst_n), .din(pol_sig), .code(cfg_presc), .dout(psc_sig)
  );

  trig_dtgen u_dt (
    .clk(clk), .rst_n(rst_n), .sel(cfg_dt_sel), .dt_en(dt_en)
  );

  trig_filter u_filt (
    .clk(clk), .rst_n(rst_n), .din(psc_sig), .code(cfg_filt), .dt_en(dt_en), .dout(filt_sig)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) filt_prev_q <= 1'b0;
    else        filt_prev_q <= filt_sig;

  assign trig_level = filt_sig;
  assign trig_rise  = filt_sig & ~filt_prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise) else $error("rise pulse wider than one cycle"); // R9
  AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_level) |-> trig_rise) else $error("missed rise pulse"); // R9
endmodule

// File: tb/tb_ext_trig_conditioner.sv
module tb_ext_trig_conditioner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_pin = 1'b0;
  logic       cfg_invert = 1'b0;
  logic [1:0] cfg_presc = 2'd0;
  logic [3:0] cfg_filt = 4'd0;
  logic [1:0] cfg_dt_sel = 2'd0;
  logic       trig_level;
  logic       trig_rise;

  int n_vec = 0;
  int n_bad = 0;
  int rises = 0;
  int rise_run = 0;
  int max_rise_run = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ext_trig_conditioner dut (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .cfg_invert(cfg_invert),
    .cfg_presc(cfg_presc), .cfg_filt(cfg_filt), .cfg_dt_sel(cfg_dt_sel),
    .trig_level(trig_level), .trig_rise(trig_rise)
  );

  // Requirement-level tables, written independently of the RTL package
  function automatic int need_of(input int code);
    if (code == 0) return 1;
    if (code < 4) return 1 << code;
    if (code < 10) return (code % 2 == 0) ? 6 : 8;
    case ((code - 10) % 3)
      0: return 5;
      1: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int div_of(input int code);
    if (code < 4) return 1;
    if (code < 10) return 2 << ((code - 4) / 2);
    if (code < 13) return 16;
    return 32;
  endfunction

  function automatic int ratio_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
  endfunction

  // Cycle model
  int m_s1, m_s2, m_pprev, m_pcnt, m_pout, m_dt, m_div, m_run, m_out, m_prev, m_last;

  always @(posedge clk) begin
    int pol, fin, dten, chg, wrap, fast, samp;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pprev = 0; m_pcnt = 0; m_pout = 0;
      m_dt = 0; m_div = 0; m_run = 0; m_out = 0; m_prev = 0; m_last = 0;
    end else begin
      pol  = m_s2 ^ int'(cfg_invert);
      fin  = (cfg_presc == 0) ? pol : m_pout;
      dten = (m_dt + 1 >= ratio_of(int'(cfg_dt_sel))) ? 1 : 0;
      chg  = (int'(cfg_filt) != m_last) ? 1 : 0;
      wrap = (m_div + 1 >= div_of(int'(cfg_filt))) ? 1 : 0;
      fast = (cfg_filt >= 1 && cfg_filt <= 3) ? 1 : 0;
      samp = (!chg && (fast || (dten && wrap))) ? 1 : 0;
      m_prev = m_out;
      if (cfg_presc == 0) m_pcnt = 0;
      else if (pol == 1 && m_pprev == 0) begin
        if (m_pcnt + 1 >= (1 << (int'(cfg_presc) - 1))) begin m_pcnt = 0; m_pout = 1 - m_pout; end
        else m_pcnt = m_pcnt + 1;
      end
      m_pprev = pol;
      if (chg) begin m_last = int'(cfg_filt); m_div = 0; m_run = 0; end
      else begin
        if (dten) m_div = wrap ? 0 : m_div + 1;
        if (samp) begin
          if (fin == m_out) m_run = 0;
          else if (m_run + 1 >= need_of(int'(cfg_filt))) begin m_out = fin; m_run = 0; end
          else m_run = m_run + 1;
        end
      end
      m_dt = dten ? 0 : m_dt + 1;
      m_s2 = m_s1; m_s1 = int'(trig_pin);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, plus pulse bookkeeping
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(trig_level) == m_out, "R4 level vs model", int'(trig_level), m_out);
      check(int'(trig_rise) == (m_out & ~m_prev & 1), "R9 rise vs model",
            int'(trig_rise), m_out & ~m_prev & 1);
      if (trig_rise) begin
        rises++;
        rise_run++;
        if (rise_run > max_rise_run) max_rise_run = rise_run;
      end else rise_run = 0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    trig_pin = 1'b0;
    repeat (3) @(negedge clk);
    check(trig_level == 1'b0 && trig_rise == 1'b0, "R1 reset outputs",
          int'({trig_level, trig_rise}), 0);
    rst_n = 1'b1;
    rises = 0;
  endtask

  task automatic hold(input logic v, input int n);
    trig_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      hold(1'b1, hi);
      hold(1'b0, lo);
    end
  endtask

  task automatic set_cfg(input logic inv, input logic [1:0] ps, input logic [3:0] fc,
                         input logic [1:0] ds);
    cfg_invert = inv; cfg_presc = ps; cfg_filt = fc; cfg_dt_sel = ds;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1 / R6: reset state and unfiltered latency
    set_cfg(1'b0, 2'd0, 4'd0, 2'd0);
    do_reset();
    hold(1'b0, 2);
    trig_pin = 1'b1;
    repeat (2) @(negedge clk);
    check(trig_level == 1'b0, "R6 level before third edge", int'(trig_level), 0);
    @(negedge clk);
    check(trig_level == 1'b1, "R6 level at third edge", int'(trig_level), 1);
    hold(1'b1, 4);

    // R2: inversion
    set_cfg(1'b1, 2'd0, 4'd0, 2'd0);
    do_reset();
    hold(1'b0, 6);
    check(trig_level == 1'b1, "R2 inverted low pin", int'(trig_level), 1);
    hold(1'b1, 6);
    check(trig_level == 1'b0, "R2 inverted high pin", int'(trig_level), 0);

    // R3: prescaler ratios
    for (int c = 1; c < 4; c++) begin
      set_cfg(1'b0, 2'(c), 4'd0, 2'd0);
      do_reset();
      pulses(16, 6, 6);
      hold(1'b0, 10);
      check(rises == 16 >> c, "R3 prescaled rise count", rises, 16 >> c);
    end

    // R4: short glitches rejected, long pulse accepted, interrupted runs restart
    set_cfg(1'b0, 2'd0, 4'd3, 2'd0);
    do_reset();
    pulses(4, 5, 10);
    check(rises == 0, "R4 five-cycle glitches", rises, 0);
    hold(1'b1, 12);
    hold(1'b1, 4);
    check(rises == 1, "R4 long pulse passes", rises, 1);
    set_cfg(1'b0, 2'd0, 4'd2, 2'd0);
    do_reset();
    pulses(10, 3, 1);
    hold(1'b0, 8);
    check(rises == 0, "R4 broken runs restart", rises, 0);

    // R5: slowest code needs a long hold
    set_cfg(1'b0, 2'd0, 4'd15, 2'd0);
    do_reset();
    hold(1'b1, 200);
    check(rises == 0, "R5 code 15 before 8 slow samples", rises, 0);
    hold(1'b1, 200);
    check(rises == 1, "R5 code 15 after 8 slow samples", rises, 1);

    // R7: dead-time ratio stretches the sampling period
    set_cfg(1'b0, 2'd0, 4'd4, 2'd2);
    do_reset();
    hold(1'b1, 30);
    check(rises == 0, "R7 ratio 4 too slow", rises, 0);
    set_cfg(1'b0, 2'd0, 4'd4, 2'd0);
    do_reset();
    hold(1'b1, 30);
    check(rises == 1, "R7 ratio 1 fast enough", rises, 1);

    // R8: code change collides with a finishing run
    set_cfg(1'b0, 2'd0, 4'd1, 2'd0);
    do_reset();
    hold(1'b1, 10);
    check(trig_level == 1'b1, "R8 level set", int'(trig_level), 1);
    trig_pin = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cfg_filt = (i % 2 == 0) ? 4'd2 : 4'd1;
      @(negedge clk);
    end
    check(trig_level == 1'b1, "R8 level held across code changes", int'(trig_level), 1);
    hold(1'b0, 10);
    check(trig_level == 1'b0, "R8 level falls once code settles", int'(trig_level), 0);

    // Random segments against the model
    do_reset();
    for (int s = 0; s < 60; s++) begin
      set_cfg(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
      for (int k = 0; k < 40; k++) begin
        if ($urandom_range(0, 9) == 0) cfg_filt = 4'($urandom_range(0, 15));
        hold(1'($urandom_range(0, 1)), $urandom_range(1, 40));
      end
    end

    // R9: pulse width over the whole run
    check(max_rise_run == 1, "R9 rise pulse width", max_rise_run, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule